// File: doc/BRIEF.md
# Enhanced Parallel Byte-Cycle Engine

This block sits between a host register port and an 8-bit parallel peripheral bus. Any host access at the address-cycle offset (3) or the data-cycle offset (4) becomes one or more byte-wide bus cycles. The engine runs such a cycle only when the host-written control register holds the exact bit pattern for the requested direction. Each byte cycle uses a request/acknowledge handshake: the engine raises an address or data strobe, waits for the peripheral's wait line to rise, drops the strobe, and then waits for the wait line to fall. A counter bounds each of the two phases. If the counter runs out, the access stops and a sticky timeout flag is set. Software reads that flag in bit 0 of the status register and clears it by writing a 1 there.

Host requests arrive on a valid/ready channel. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. While an access is in flight, or while its response waits to be taken, `req_ready` stays low. Every request, read or write, gets exactly one response beat on `rsp_valid`. That beat holds, with `rsp_rdata` stable, until `rsp_ready` is sampled high, so a stalled consumer holds back the whole engine. Wide data-offset accesses (16 or 32 bits) are split into byte cycles, least significant byte first.

Top module: `pbus_cycle_engine`

## Requirements
- R1: After reset the control register reads 0xCC, status reads 0, no strobe or write line is active, `rsp_valid` is low and `req_ready` is high.
- R2: A write to offset 2 stores the low data byte, and bits 7:6 always read back as 1.
- R3: A write at offset 3 or 4 runs bus cycles only when (control AND 0x2F) equals 0x04. Otherwise no strobe rises and the flag is unchanged.
- R4: A read at offset 3 or 4 runs bus cycles only when (control AND 0x2F) equals 0x24. Otherwise no strobe rises and the response is all ones at the access width (size 0: 0xFF, 1: 0xFFFF, 2 or 3: 0xFFFFFFFF).
- R5: Offset 3 drives `per_astb` and offset 4 drives `per_dstb`, never both at once. `per_write` is high throughout a write access. A strobe stays high until `per_wait` is seen high, then drops, and the next byte waits for `per_wait` to be low.
- R6: At offset 4, size 1 makes two byte cycles and size 2 or 3 makes four, sending bits 7:0 first. Offset 3 always makes a single byte cycle carrying bits 7:0.
- R7: A read byte is taken from `per_din` while `per_wait` is high and placed little-endian in `rsp_rdata`. Bits above the access width read 0.
- R8: If `per_wait` does not change within WAIT_LIMIT cycles of a phase, the access ends, the remaining bytes are skipped, uncaptured read bytes return 0xFF, and status bit 0 becomes 1.
- R9: The timeout flag stays set until a status write (offset 1) with data bit 0 set. A status write with bit 0 clear leaves it set.
- R10: Any address with bit 10 set is ignored on write (control unchanged) and returns 0xFF on read.
- R11: `req_ready` is low from acceptance until the response is taken. `rsp_valid` and `rsp_rdata` hold steady while `rsp_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Engine can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Register offset |
| req_size | input | 2 | 0 byte, 1 half, 2/3 word (data offset only) |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response beat present |
| rsp_ready | input | 1 | Host takes response |
| rsp_rdata | output | 32 | Read data (0 for writes) |
| per_astb | output | 1 | Address strobe, active high |
| per_dstb | output | 1 | Data strobe, active high |
| per_write | output | 1 | High during write accesses |
| per_oe | output | 1 | Engine drives `per_dout` |
| per_dout | output | 8 | Byte to peripheral |
| per_din | input | 8 | Byte from peripheral |
| per_wait | input | 1 | Peripheral handshake line |

## Verification
The bench builds the engine with WAIT_LIMIT set to 6. This makes a missing acknowledge end within a few cycles, so the timeout path can be exercised many times in a short run. A behavioural peripheral answers after zero to two cycles, well inside that limit, and can be told to stop acknowledging after a set number of bytes. That option reaches a timeout partway through a 32-bit access, where the skipped bytes and the 0xFF fill are visible. The address width of 11 puts the ignored window at bit 10.

// File: rtl/pbus_pkg.sv
package pbus_pkg;
  localparam int unsigned LANES = 4;
  localparam logic [7:0] CTRL_GATE_MASK  = 8'h2F;
  localparam logic [7:0] CTRL_WR_PATTERN = 8'h04;
  localparam logic [7:0] CTRL_RD_PATTERN = 8'h24;
  localparam logic [7:0] CTRL_FIXED_ONES = 8'hC0;
  localparam logic [7:0] CTRL_RESET      = 8'hCC;
  localparam logic [2:0] OFS_STATUS = 3'd1;
  localparam logic [2:0] OFS_CTRL   = 3'd2;
  localparam logic [2:0] OFS_ACYC   = 3'd3;
  localparam logic [2:0] OFS_DCYC   = 3'd4;
  localparam int unsigned EXT_BIT = 10;

  function automatic logic [31:0] width_ones(input logic [1:0] sz);
    case (sz)
      2'd0:    width_ones = 32'h0000_00FF;
      2'd1:    width_ones = 32'h0000_FFFF;
      default: width_ones = 32'hFFFF_FFFF;
    endcase
  endfunction

  function automatic logic [1:0] final_lane(input logic [1:0] sz);
    case (sz)
      2'd0:    final_lane = 2'd0;
      2'd1:    final_lane = 2'd1;
      default: final_lane = 2'd3;
    endcase
  endfunction
endpackage

// File: rtl/pbus_ctrl_regs.sv
module pbus_ctrl_regs
  import pbus_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctrl_we,
  input  logic [7:0] ctrl_wdata,
  input  logic       set_flag,
  input  logic       clr_flag,
  output logic [7:0] ctrl_q,
  output logic       flag_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= CTRL_RESET;
      flag_q <= 1'b0;
    end else begin
      if (ctrl_we) ctrl_q <= ctrl_wdata | CTRL_FIXED_ONES;
      if (set_flag) flag_q <= 1'b1;
      else if (clr_flag) flag_q <= 1'b0;
    end
  end

  assert_flag_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
    set_flag |=> flag_q);
  assert_flag_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_flag && !set_flag) |=> !flag_q);
  assert_fixed_ones_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_we |=> (ctrl_q[7:6] == 2'b11));
endmodule

// File: rtl/pbus_byte_seq.sv
module pbus_byte_seq
  import pbus_pkg::*;
#(
  parameter int unsigned WAIT_LIMIT = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        is_write,
  input  logic        use_astb,
  input  logic [1:0]  last_lane,
  input  logic [31:0] wdata,
  input  logic [31:0] rdata_init,
  output logic        done,
  output logic        fail,
  output logic [31:0] rdata,
  output logic        per_astb,
  output logic        per_dstb,
  output logic        per_write,
  output logic        per_oe,
  output logic [7:0]  per_dout,
  input  logic [7:0]  per_din,
  input  logic        per_wait
);
  localparam int unsigned TW = $clog2(WAIT_LIMIT + 1);
  localparam logic [TW-1:0] TLAST = TW'(WAIT_LIMIT - 1);

  typedef enum logic [1:0] {SQ_IDLE, SQ_ASSERT, SQ_RELEASE} sq_state_e;
  sq_state_e st;
  logic [1:0]    lane, last_r;
  logic          wr_r, astb_r;
  logic [31:0]   wdata_r;
  logic [TW-1:0] timer;
  logic          expired;

  assign expired   = (timer == TLAST);
  assign per_astb  = (st == SQ_ASSERT) && astb_r;
  assign per_dstb  = (st == SQ_ASSERT) && !astb_r;
  assign per_write = (st != SQ_IDLE) && wr_r;
  assign per_oe    = per_write;
  assign per_dout  = wdata_r[{lane, 3'b000} +: 8];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= SQ_IDLE; lane <= '0; last_r <= '0; wr_r <= 1'b0; astb_r <= 1'b0;
      wdata_r <= '0; rdata <= '0; timer <= '0; done <= 1'b0; fail <= 1'b0;
    end else begin
      done <= 1'b0;
      fail <= 1'b0;
      case (st)
        SQ_IDLE: if (start) begin
          wr_r <= is_write; astb_r <= use_astb; last_r <= last_lane;
          wdata_r <= wdata; rdata <= rdata_init;
          lane <= '0; timer <= '0; st <= SQ_ASSERT;
        end
        SQ_ASSERT: begin
          if (per_wait) begin
            if (!wr_r) rdata[{lane, 3'b000} +: 8] <= per_din;
            timer <= '0;
            st <= SQ_RELEASE;
          end else if (expired) begin
            st <= SQ_IDLE; done <= 1'b1; fail <= 1'b1;
          end else begin
            timer <= timer + 1'b1;
          end
        end
        SQ_RELEASE: begin
          if (!per_wait) begin
            timer <= '0;
            if (lane == last_r) begin
              st <= SQ_IDLE; done <= 1'b1;
            end else begin
              lane <= lane + 1'b1; st <= SQ_ASSERT;
            end
          end else if (expired) begin
            st <= SQ_IDLE; done <= 1'b1; fail <= 1'b1;
          end else begin
            timer <= timer + 1'b1;
          end
        end
        default: st <= SQ_IDLE;
      endcase
    end
  end

  assert_timer_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    timer <= TLAST);
  assert_ack_releases_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == SQ_ASSERT && per_wait) |=> (st == SQ_RELEASE && !per_astb && !per_dstb));
  assert_strobe_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(per_astb && per_dstb));
endmodule

// File: rtl/pbus_cycle_engine.sv
module pbus_cycle_engine
  import pbus_pkg::*;
#(
  parameter int unsigned ADDR_W     = 11,
  parameter int unsigned WAIT_LIMIT = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [31:0]       rsp_rdata,
  output logic              per_astb,
  output logic              per_dstb,
  output logic              per_write,
  output logic              per_oe,
  output logic [7:0]        per_dout,
  input  logic [7:0]        per_din,
  input  logic              per_wait
);
  typedef enum logic [1:0] {T_IDLE, T_RUN, T_RESP} top_state_e;
  top_state_e st;

  logic [7:0]  ctrl_q;
  logic        flag_q;
  logic        accept, in_ext, lo_hit, is_cyc, gate_ok, seq_start;
  logic        ctrl_we, clr_flag;
  logic [1:0]  cyc_size;
  logic [31:0] imm_rdata, seq_init, seq_rdata;
  logic        seq_done, seq_fail;

  assign req_ready = (st == T_IDLE);
  assign rsp_valid = (st == T_RESP);
  assign accept    = req_valid && req_ready;

  assign in_ext   = |req_addr[ADDR_W-1:EXT_BIT];
  assign lo_hit   = (req_addr[ADDR_W-1:3] == '0);
  assign is_cyc   = lo_hit && (req_addr[2:0] == OFS_ACYC || req_addr[2:0] == OFS_DCYC);
  assign cyc_size = (req_addr[2:0] == OFS_DCYC) ? req_size : 2'd0;
  assign gate_ok  = ((ctrl_q & CTRL_GATE_MASK) ==
                     (req_write ? CTRL_WR_PATTERN : CTRL_RD_PATTERN));
  assign seq_start = accept && is_cyc && gate_ok;
  assign ctrl_we   = accept && req_write && lo_hit && req_addr[2:0] == OFS_CTRL;
  assign clr_flag  = accept && req_write && lo_hit && req_addr[2:0] == OFS_STATUS
                     && req_wdata[0];
  assign seq_init  = req_write ? 32'h0 : width_ones(cyc_size);

  always_comb begin
    imm_rdata = 32'h0000_00FF;
    if (req_write) imm_rdata = '0;
    else if (in_ext || !lo_hit) imm_rdata = 32'h0000_00FF;
    else if (req_addr[2:0] == OFS_CTRL) imm_rdata = {24'h0, ctrl_q};
    else if (req_addr[2:0] == OFS_STATUS) imm_rdata = {31'h0, flag_q};
    else if (is_cyc) imm_rdata = width_ones(cyc_size);
  end

  pbus_ctrl_regs u_regs (
    .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_wdata(req_wdata[7:0]),
    .set_flag(seq_fail), .clr_flag(clr_flag), .ctrl_q(ctrl_q), .flag_q(flag_q)
  );

  pbus_byte_seq #(.WAIT_LIMIT(WAIT_LIMIT)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(seq_start), .is_write(req_write),
    .use_astb(req_addr[2:0] == OFS_ACYC), .last_lane(final_lane(cyc_size)),
    .wdata(req_wdata), .rdata_init(seq_init), .done(seq_done), .fail(seq_fail),
    .rdata(seq_rdata), .per_astb(per_astb), .per_dstb(per_dstb),
    .per_write(per_write), .per_oe(per_oe), .per_dout(per_dout),
    .per_din(per_din), .per_wait(per_wait)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= T_IDLE;
      rsp_rdata <= '0;
    end else begin
      case (st)
        T_IDLE: if (accept) begin
          if (seq_start) st <= T_RUN;
          else begin
            rsp_rdata <= imm_rdata;
            st <= T_RESP;
          end
        end
        T_RUN: if (seq_done) begin
          rsp_rdata <= seq_rdata;
          st <= T_RESP;
        end
        T_RESP: if (rsp_ready) st <= T_IDLE;
        default: st <= T_IDLE;
      endcase
    end
  end

  assert_rsp_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));
  assert_no_accept_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid || per_astb || per_dstb) |-> !req_ready);
  assert_gate_pattern_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (per_astb || per_dstb) |->
      ((ctrl_q & CTRL_GATE_MASK) == (per_write ? CTRL_WR_PATTERN : CTRL_RD_PATTERN)));
endmodule

// File: tb/pbus_cycle_engine_bench.sv
module pbus_cycle_engine_bench;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 11;
  localparam int WAIT_LIMIT = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b1;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [1:0] req_size = '0;
  logic [31:0] req_wdata = '0;
  logic req_ready, rsp_valid, per_astb, per_dstb, per_write, per_oe, per_wait_r;
  logic [31:0] rsp_rdata;
  logic [7:0] per_dout, per_din;

  int checks = 0, errors = 0;
  int dly = 1, budget = -1, cnt = 0, rd_ctr = 0, exp_ctr = 0, strobe_rises = 0;
  int ctrl_m = 8'hCC;
  bit in_access = 1'b0, prev_strobe = 1'b0;
  logic [9:0] obs_q[$];
  logic [9:0] exp_q[$];
  logic [31:0] rd;

  always #(CLK_PERIOD/2) clk = ~clk;

  pbus_cycle_engine #(.ADDR_W(ADDR_W), .WAIT_LIMIT(WAIT_LIMIT)) u_pbus_cycle_engine (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_size(req_size),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_rdata(rsp_rdata), .per_astb(per_astb), .per_dstb(per_dstb),
    .per_write(per_write), .per_oe(per_oe), .per_dout(per_dout),
    .per_din(per_din), .per_wait(per_wait_r)
  );

  assign per_din = 8'(8'h30 + rd_ctr);

  // behavioural peripheral
  always @(posedge clk) begin
    bit s;
    s = per_astb || per_dstb;
    if (s && !prev_strobe) strobe_rises++;
    prev_strobe = s;
    if (!rst_n) begin
      per_wait_r <= 1'b0; cnt = 0;
    end else if (s && !per_wait_r) begin
      if (budget != 0) begin
        if (cnt >= dly) begin
          per_wait_r <= 1'b1; cnt = 0;
          obs_q.push_back({per_astb, per_write, per_write ? per_dout : per_din});
          if (budget > 0) budget--;
        end else cnt++;
      end
    end else if (!s && per_wait_r) begin
      if (cnt >= dly) begin
        per_wait_r <= 1'b0; cnt = 0;
        if (!per_write) rd_ctr++;
      end else cnt++;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // per-clock comparison against the model's view
  always @(negedge clk) if (rst_n) begin
    chk("R5 strobes exclusive", {31'h0, per_astb && per_dstb}, 32'h0);
    if (!in_access) chk("R11 idle no strobe", {31'h0, per_astb || per_dstb}, 32'h0);
    if (per_astb || per_dstb)
      chk("R3/R4 gate during cycle", ctrl_m & 8'h2F, per_write ? 32'h04 : 32'h24);
  end

  task automatic access(input bit wr, input int addr, input int sz,
                        input logic [31:0] wd, output logic [31:0] rdv);
    in_access = 1'b1;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = ADDR_W'(addr);
    req_size = 2'(sz); req_wdata = wd;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_valid) @(negedge clk);
    rdv = rsp_rdata;
    @(negedge clk);
    in_access = 1'b0;
  endtask

  task automatic exp_byte(input bit astb, input bit wr, input logic [7:0] b);
    exp_q.push_back({astb, wr, b});
  endtask

  task automatic cmp_log(input string tag);
    chk({tag, " byte count"}, obs_q.size(), exp_q.size());
    for (int i = 0; i < exp_q.size() && i < obs_q.size(); i++)
      chk({tag, " byte"}, {22'h0, obs_q[i]}, {22'h0, exp_q[i]});
    obs_q.delete(); exp_q.delete();
  endtask

  function automatic logic [7:0] next_rd();
    logic [7:0] b;
    b = 8'(8'h30 + exp_ctr);
    exp_ctr++;
    return b;
  endfunction

  task automatic set_ctrl(input int v);
    access(1, 2, 0, 32'(v), rd);
    ctrl_m = v | 8'hC0;
  endtask

  initial begin
    logic [7:0] b0, b1, b2, b3;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk("R1 req_ready", {31'h0, req_ready}, 32'h1);
    chk("R1 rsp_valid", {31'h0, rsp_valid}, 32'h0);
    chk("R1 pins idle", {28'h0, per_astb, per_dstb, per_write, per_oe}, 32'h0);
    access(0, 2, 0, 0, rd); chk("R1 ctrl reset", rd, 32'hCC);
    access(0, 1, 0, 0, rd); chk("R1 status reset", rd, 32'h0);

    // R3/R4 with reset control pattern
    access(1, 4, 2, 32'h1234_5678, rd); cmp_log("R3 blocked write");
    access(0, 4, 2, 0, rd); chk("R4 blocked word", rd, 32'hFFFF_FFFF);
    access(0, 4, 1, 0, rd); chk("R4 blocked half", rd, 32'h0000_FFFF);
    access(0, 3, 0, 0, rd); chk("R4 blocked byte", rd, 32'h0000_00FF);
    cmp_log("R4 blocked reads");

    // R2
    set_ctrl(8'h3F); access(0, 2, 0, 0, rd); chk("R2 readback 3F", rd, 32'hFF);
    set_ctrl(8'h04); access(0, 2, 0, 0, rd); chk("R2 readback 04", rd, 32'hC4);

    // R5/R6 writes
    dly = 1;
    access(1, 3, 0, 32'h0000_005A, rd); exp_byte(1, 1, 8'h5A); cmp_log("R5 addr write");
    access(1, 4, 2, 32'h1122_3344, rd);
    exp_byte(0,1,8'h44); exp_byte(0,1,8'h33); exp_byte(0,1,8'h22); exp_byte(0,1,8'h11);
    cmp_log("R6 word write");
    dly = 0;
    access(1, 4, 1, 32'h0000_BEEF, rd); exp_byte(0,1,8'hEF); exp_byte(0,1,8'hBE);
    cmp_log("R6 half write");
    access(1, 3, 2, 32'hCAFE_1234, rd); exp_byte(1,1,8'h34); cmp_log("R6 addr single byte");
    access(0, 4, 0, 0, rd); chk("R4 read under write pattern", rd, 32'hFF);
    cmp_log("R4 no cycle");

    // R7 reads
    set_ctrl(8'h24);
    access(1, 4, 0, 32'h77, rd); cmp_log("R3 write under read pattern");
    dly = 2;
    b0 = next_rd(); b1 = next_rd(); b2 = next_rd(); b3 = next_rd();
    access(0, 4, 2, 0, rd); chk("R7 word read", rd, {b3, b2, b1, b0});
    exp_byte(0,0,b0); exp_byte(0,0,b1); exp_byte(0,0,b2); exp_byte(0,0,b3);
    cmp_log("R7 word read log");
    dly = 0;
    b0 = next_rd(); b1 = next_rd();
    access(0, 4, 1, 0, rd); chk("R7 half read", rd, {16'h0, b1, b0});
    exp_byte(0,0,b0); exp_byte(0,0,b1); cmp_log("R7 half log");
    b0 = next_rd();
    access(0, 3, 0, 0, rd); chk("R5 addr read", rd, {24'h0, b0});
    exp_byte(1,0,b0); cmp_log("R5 addr read log");

    // R8 timeout mid-word
    budget = 2; strobe_rises = 0;
    b0 = next_rd(); b1 = next_rd();
    access(0, 4, 2, 0, rd); chk("R8 partial read", rd, {16'hFFFF, b1, b0});
    chk("R8 bytes skipped", strobe_rises, 3);
    exp_byte(0,0,b0); exp_byte(0,0,b1); cmp_log("R8 log");
    budget = -1;
    access(0, 1, 0, 0, rd); chk("R8 flag set", rd, 32'h1);
    // R9
    access(1, 1, 0, 32'hFE, rd); access(0, 1, 0, 0, rd); chk("R9 bit0 clear keeps", rd, 32'h1);
    access(1, 1, 0, 32'h01, rd); access(0, 1, 0, 0, rd); chk("R9 clear", rd, 32'h0);
    // R8 write timeout
    set_ctrl(8'h04); budget = 0;
    access(1, 4, 1, 32'hABCD, rd); cmp_log("R8 write timeout log");
    budget = -1;
    access(0, 1, 0, 0, rd); chk("R8 write timeout flag", rd, 32'h1);

    // R10
    access(1, 32'h402, 0, 32'h00, rd); access(0, 2, 0, 0, rd); chk("R10 write ignored", rd, 32'hC4);
    access(0, 32'h400, 0, 0, rd); chk("R10 read 400", rd, 32'hFF);
    access(0, 32'h7FF, 0, 0, rd); chk("R10 read 7FF", rd, 32'hFF);

    // R11 back-pressure
    in_access = 1'b1; rsp_ready = 1'b0;
    @(negedge clk); req_valid = 1'b1; req_write = 1'b0; req_addr = 2;
    @(negedge clk); req_valid = 1'b0;
    repeat (4) @(negedge clk);
    chk("R11 rsp held", {31'h0, rsp_valid}, 32'h1);
    chk("R11 data held", rsp_rdata, 32'hC4);
    chk("R11 not ready", {31'h0, req_ready}, 32'h0);
    rsp_ready = 1'b1; @(negedge clk);
    chk("R11 released", {31'h0, req_ready}, 32'h1);
    in_access = 1'b0;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule